// File: doc/BRIEF.md
# Arbitrated Dual-CPU Mailbox Memory

This block lets two independent processors exchange messages through one single-ported array of 16-bit words. Each processor has its own port with a request strobe, a write flag, an address, write data, a ready output and a read-data output. A fixed-priority arbiter gives the array to one port per cycle. Port A belongs to the real-time processor and is never held off. Port B waits while A is using the array.

The address space is split into two equal mailboxes, one for each direction. The lowest word of each half is a command/status word. A sender writes its payload words, then writes a nonzero code into the command word, then polls that word until the receiver clears it to zero. The receiver polls the same word, copies the payload and writes zero. Two status outputs show whether each command word currently holds a nonzero value.

Port B's processor orders the bytes of a word the opposite way from port A's. The block therefore exchanges the two bytes on B's write path and on B's read path, so both processors see the same values. The array holds words in port A's byte order.

Top module: `dual_cpu_mailbox`

## Requirements
- R1: While `a_req` is high, `a_rdy` is high in the same cycle, and the access completes at the next rising edge whatever port B is doing.
- R2: `b_rdy` is high only when `b_req` is high and `a_req` is low. When both ports request in the same cycle, B is stalled with `b_rdy` low. At most one ready is high in any cycle.
- R3: A granted write updates the addressed word at the rising edge that ends its ready cycle. A granted read delivers the word on that port's read-data output after the same edge. The read data then holds until that port's next granted read.
- R4: Addresses with the top address bit at 0 form the B-to-A mailbox, whose command word is at address 0x000. Addresses with the top bit at 1 form the A-to-B mailbox, whose command word is at address 0x400. A write to any other word has no effect on either status output.
- R5: `to_a_pending` is high exactly when the word at 0x000 is nonzero. It changes in the cycle after the write that changes that word.
- R6: `to_b_pending` is high exactly when the word at 0x400 is nonzero. It changes in the cycle after the write that changes that word.
- R7: Port B's bytes are exchanged on both reads and writes. A value 0x1234 written by A reads as 0x3412 on B. A value 0xABCD written by B reads as 0xCDAB on A and as 0xABCD on B.
- R8: Reset clears both command words, both status outputs and both read-data outputs to zero, including when reset is applied in the middle of operation.
- R9: A stalled B request completes in the first cycle that A does not request. When A and B write the same word in the same cycle, the word ends up holding B's value, because B's write lands afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 11 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdy | output | 1 | Port A granted this cycle |
| a_rdata | output | 16 | Port A read data, registered |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 11 | Port B word address |
| b_wdata | input | 16 | Port B write data, B byte order |
| b_rdy | output | 1 | Port B granted this cycle |
| b_rdata | output | 16 | Port B read data, B byte order, registered |
| to_a_pending | output | 1 | Command word at 0x000 is nonzero |
| to_b_pending | output | 1 | Command word at 0x400 is nonzero |

## Verification
The assertions assume that each requester keeps its request, write flag, address and data steady until its ready is seen. They also assume that the inputs carry known values once reset is released. Under these conditions the status checks can tie a command-word write directly to the status change in the next cycle. The bench changes inputs only on falling edges. It keeps B's request asserted, without changing it, across every stalled cycle. It releases a request only after the edge on which its ready was high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DATA_W = 16;
  localparam int MBX_ADDR_W = 11;
  localparam int MBX_LANE_W = 8;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
  import mbx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   a_req,
  input  logic   b_req,
  output owner_e owner
);

  always_comb begin
    if (a_req)      owner = OWN_A;
    else if (b_req) owner = OWN_B;
    else            owner = OWN_NONE;
  end

  // R1: the real-time side is never held off
  a_r1_a_never_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    a_req |-> (owner == OWN_A));

  // R2: no grant goes to a side that is not asking
  a_r2_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_B) |-> (b_req && !a_req));

endmodule

// File: rtl/mbx_lane_swap.sv
module mbx_lane_swap #(
  parameter int W      = 16,
  parameter int LANE_W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int LANES = W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              to_a_pending,
  output logic              to_b_pending
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CMD_BA = '0;
  localparam logic [ADDR_W-1:0] CMD_AB = ADDR_W'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] cmd_ba_q, cmd_ba_d;
  logic [DATA_W-1:0] cmd_ab_q, cmd_ab_d;
  logic              wr_en;
  logic              hit_ba, hit_ab;

  assign wr_en  = en && we;
  assign hit_ba = (addr == CMD_BA);
  assign hit_ab = (addr == CMD_AB);

  // payload array: no reset, contents undefined after reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  // command words live in resettable flops
  always_comb begin
    cmd_ba_d = cmd_ba_q;
    cmd_ab_d = cmd_ab_q;
    if (wr_en && hit_ba) cmd_ba_d = wdata;
    if (wr_en && hit_ab) cmd_ab_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ba_q <= '0;
      cmd_ab_q <= '0;
    end else begin
      cmd_ba_q <= cmd_ba_d;
      cmd_ab_q <= cmd_ab_d;
    end
  end

  always_comb begin
    if (hit_ba)      rd_word = cmd_ba_q;
    else if (hit_ab) rd_word = cmd_ab_q;
    else             rd_word = mem[addr];
  end

  assign to_a_pending = |cmd_ba_q;
  assign to_b_pending = |cmd_ab_q;

  // R5: a nonzero write to the B-to-A command word raises its status
  a_r5_set_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ba && (wdata != '0)) |=> to_a_pending);
  // R5: writing zero completes the command
  a_r5_clear_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ba && (wdata == '0)) |=> !to_a_pending);
  // R6: same for the A-to-B command word
  a_r6_set_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ab && (wdata != '0)) |=> to_b_pending);
  a_r6_clear_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ab && (wdata == '0)) |=> !to_b_pending);
  // R4: other words leave the status untouched
  a_r4_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (hit_ba || hit_ab)) |=> $stable({to_a_pending, to_b_pending}));

endmodule

// File: rtl/dual_cpu_mailbox.sv
module dual_cpu_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = MBX_DATA_W,
  parameter int ADDR_W = MBX_ADDR_W,
  parameter int LANE_W = MBX_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_rdy,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_rdy,
  output logic [DATA_W-1:0] b_rdata,
  output logic              to_a_pending,
  output logic              to_b_pending
);

  owner_e            owner;
  logic              gnt_a, gnt_b;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] b_wdata_sw;
  logic [DATA_W-1:0] rd_word, rd_word_sw;
  logic [DATA_W-1:0] a_rdata_q, a_rdata_d;
  logic [DATA_W-1:0] b_rdata_q, b_rdata_d;
  logic              a_rd_en, b_rd_en;

  mbx_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .a_req (a_req),
    .b_req (b_req),
    .owner (owner)
  );

  assign gnt_a = (owner == OWN_A);
  assign gnt_b = (owner == OWN_B);
  assign a_rdy = gnt_a;
  assign b_rdy = gnt_b;

  mbx_lane_swap #(.W(DATA_W), .LANE_W(LANE_W)) u_swap_wr (
    .din  (b_wdata),
    .dout (b_wdata_sw)
  );

  mbx_lane_swap #(.W(DATA_W), .LANE_W(LANE_W)) u_swap_rd (
    .din  (rd_word),
    .dout (rd_word_sw)
  );

  always_comb begin
    mem_en    = gnt_a || gnt_b;
    mem_we    = gnt_a ? a_we    : b_we;
    mem_addr  = gnt_a ? a_addr  : b_addr;
    mem_wdata = gnt_a ? a_wdata : b_wdata_sw;
  end

  mbx_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (mem_en),
    .we           (mem_we),
    .addr         (mem_addr),
    .wdata        (mem_wdata),
    .rd_word      (rd_word),
    .to_a_pending (to_a_pending),
    .to_b_pending (to_b_pending)
  );

  // per-port read registers with explicit enables
  assign a_rd_en = gnt_a && !a_we;
  assign b_rd_en = gnt_b && !b_we;

  always_comb begin
    a_rdata_d = a_rdata_q;
    b_rdata_d = b_rdata_q;
    if (a_rd_en) a_rdata_d = rd_word;
    if (b_rd_en) b_rdata_d = rd_word_sw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      a_rdata_q <= a_rdata_d;
      b_rdata_q <= b_rdata_d;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;

  // R2: the array has a single owner per cycle
  a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_rdy, b_rdy}));
  // R2: a collision always stalls port B
  a_r2_b_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && b_req) |-> !b_rdy);
  // R3: read data holds when no read is granted to port A
  a_r3_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rdy && !a_we) |=> $stable(a_rdata));
  // R3: same for port B
  a_r3_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_rdy && !b_we) |=> $stable(b_rdata));

endmodule

// File: tb/tb_dual_cpu_mailbox.sv
module tb_dual_cpu_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 11;

  logic          clk;
  logic          rst_n;
  logic          a_req, a_we, b_req, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic          a_rdy, b_rdy;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          to_a_pending, to_b_pending;

  int n_checks = 0;
  int n_fails  = 0;

  dual_cpu_mailbox dut (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdy(a_rdy), .a_rdata(a_rdata),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdy(b_rdy), .b_rdata(b_rdata),
    .to_a_pending(to_a_pending), .to_b_pending(to_b_pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic idle_inputs();
    a_req = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_req = 0; b_we = 0; b_addr = '0; b_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one access on port A; returns at the falling edge after its edge
  task automatic a_op(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    @(negedge clk);
    a_req = 1; a_we = we; a_addr = addr; a_wdata = wd;
    #1 chk("R1 a_rdy on request", DW'(a_rdy), 16'h1);
    @(negedge clk);
    a_req = 0; a_we = 0;
  endtask

  task automatic b_op(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    @(negedge clk);
    b_req = 1; b_we = we; b_addr = addr; b_wdata = wd;
    #1;
    while (!b_rdy) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    b_req = 0; b_we = 0;
  endtask

  task automatic t_reset_state();
    chk("R8 to_a_pending after reset", DW'(to_a_pending), 16'h0);
    chk("R8 to_b_pending after reset", DW'(to_b_pending), 16'h0);
    chk("R8 a_rdata after reset", a_rdata, 16'h0);
    chk("R8 b_rdata after reset", b_rdata, 16'h0);
    a_op(0, 11'h000, '0);
    chk("R8 command word B-to-A cleared", a_rdata, 16'h0);
    b_op(0, 11'h400, '0);
    chk("R8 command word A-to-B cleared", b_rdata, 16'h0);
  endtask

  task automatic t_priority();
    // both request in the same cycle, same word
    @(negedge clk);
    a_req = 1; a_we = 1; a_addr = 11'h005; a_wdata = 16'h1111;
    b_req = 1; b_we = 1; b_addr = 11'h005; b_wdata = 16'h3344;
    #1;
    chk("R1 a_rdy in collision", DW'(a_rdy), 16'h1);
    chk("R2 b_rdy low in collision", DW'(b_rdy), 16'h0);
    // A keeps requesting a second cycle: B still stalled
    @(negedge clk);
    a_addr = 11'h006; a_wdata = 16'h2222;
    #1;
    chk("R2 b stalled while A busy", DW'(b_rdy), 16'h0);
    chk("R1 a_rdy second cycle", DW'(a_rdy), 16'h1);
    @(negedge clk);
    a_req = 0; a_we = 0;
    #1 chk("R9 b granted once A releases", DW'(b_rdy), 16'h1);
    @(negedge clk);
    b_req = 0; b_we = 0;
    #1 chk("R2 no ready when idle", DW'({a_rdy, b_rdy}), 16'h0);
    a_op(0, 11'h005, '0);
    chk("R9 B write lands after A", a_rdata, 16'h4433);
    a_op(0, 11'h006, '0);
    chk("R3 A second write stored", a_rdata, 16'h2222);
  endtask

  task automatic t_swap();
    a_op(1, 11'h014, 16'h1234);
    b_op(0, 11'h014, '0);
    chk("R7 B reads A value swapped", b_rdata, 16'h3412);
    b_op(1, 11'h015, 16'hABCD);
    a_op(0, 11'h015, '0);
    chk("R7 A reads B value swapped", a_rdata, 16'hCDAB);
    b_op(0, 11'h015, '0);
    chk("R7 B reads its own value", b_rdata, 16'hABCD);
  endtask

  task automatic t_read_hold();
    a_op(1, 11'h030, 16'h5A5A);
    a_op(0, 11'h030, '0);
    chk("R3 read after write", a_rdata, 16'h5A5A);
    a_op(1, 11'h031, 16'h0F0F);
    chk("R3 a_rdata holds over write", a_rdata, 16'h5A5A);
    b_op(0, 11'h031, '0);
    chk("R3 a_rdata holds over B read", a_rdata, 16'h5A5A);
    chk("R3 B read data", b_rdata, 16'h0F0F);
  endtask

  task automatic t_mailbox_a_to_b();
    a_op(1, 11'h401, 16'hC001);
    a_op(1, 11'h402, 16'hC002);
    chk("R6 payload leaves to_b_pending low", DW'(to_b_pending), 16'h0);
    a_op(1, 11'h400, 16'h0007);
    chk("R6 command sets to_b_pending", DW'(to_b_pending), 16'h1);
    chk("R5 other status unaffected", DW'(to_a_pending), 16'h0);
    b_op(0, 11'h400, '0);
    chk("R7 B polls command", b_rdata, 16'h0700);
    b_op(0, 11'h402, '0);
    chk("R4 B copies payload", b_rdata, 16'h02C0);
    b_op(1, 11'h400, 16'h0000);
    chk("R6 zero clears to_b_pending", DW'(to_b_pending), 16'h0);
    a_op(0, 11'h400, '0);
    chk("R6 A sees command done", a_rdata, 16'h0000);
  endtask

  task automatic t_mailbox_b_to_a();
    a_op(1, 11'h001, 16'hFFFF);
    a_op(1, 11'h3FF, 16'hFFFF);
    a_op(1, 11'h401, 16'hFFFF);
    chk("R4 non-command words: to_a_pending", DW'(to_a_pending), 16'h0);
    chk("R4 non-command words: to_b_pending", DW'(to_b_pending), 16'h0);
    b_op(1, 11'h000, 16'h00FF);
    chk("R5 B command sets to_a_pending", DW'(to_a_pending), 16'h1);
    a_op(0, 11'h000, '0);
    chk("R5 A reads command", a_rdata, 16'hFF00);
    a_op(1, 11'h000, 16'h0000);
    chk("R5 zero clears to_a_pending", DW'(to_a_pending), 16'h0);
  endtask

  task automatic t_reset_mid();
    a_op(1, 11'h400, 16'h0101);
    b_op(1, 11'h000, 16'h0202);
    b_op(0, 11'h015, '0);
    chk("R8 both pending before reset", DW'({to_a_pending, to_b_pending}), 16'h3);
    do_reset();
    chk("R8 pendings cleared by reset", DW'({to_a_pending, to_b_pending}), 16'h0);
    chk("R8 b_rdata cleared by reset", b_rdata, 16'h0);
    a_op(0, 11'h000, '0);
    chk("R8 B-to-A command word zero", a_rdata, 16'h0);
    a_op(0, 11'h400, '0);
    chk("R8 A-to-B command word zero", a_rdata, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    do_reset();
    t_reset_state();
    t_priority();
    t_swap();
    t_read_hold();
    t_mailbox_a_to_b();
    t_mailbox_b_to_a();
    t_reset_mid();
    summary();
    $finish;
  end

endmodule